// File: doc/BRIEF.md
# Radio Power-Up Sequencer

This block sits on the host side of a low-power radio module and brings the module out of reset in the order the module needs. It then hands the module over for firmware loading. Later it takes the module down safely. The block drives the module's active-low reset pin and its active-high power-enable pin. It watches a free-running 32.768 kHz sleep clock, which is brought into the system clock domain through a two-flop synchroniser. It also counts millisecond delays with a timer derived from the system clock frequency.

Once the supplies are present and the sleep clock is stable, the block holds reset for a number of full sleep-clock periods and then releases it. It enables module power, waits out the settling time, and writes a wake-up bit into a module register through an attached serial master port. It then waits for the module's ready bit and interrupt together, and raises a go signal to the firmware loader. When the loader reports that initialisation is done, the block clears the wake-up bit with a second register write.

A power-down request always wins over the rest of the sequence. It puts the module back into reset and allows some sleep-clock periods to pass before it tells the system to remove the supplies.

Top module: `radio_pwrseq`

## Requirements
- R1: After a power-up request, the module reset stays low until `io_good` is high and STABLE_EDGES rising edges of the sleep clock have been seen while it stays high. A stopped sleep clock or a low `io_good` keeps the module in reset. After controller reset, `mod_rst_n`, `mod_pwr_en`, `wr_req`, `fw_go`, `supply_off` and `seq_err` are all low.
- R2: After qualification, reset is held for RST_SLOW_CYC+1 further synchronised sleep-clock rising edges, which is at least RST_SLOW_CYC full periods, and only then is it released.
- R3: `mod_pwr_en` rises exactly one system clock after `mod_rst_n` rises, and never while reset is asserted.
- R4: No register write is requested sooner than ACCESS_WAIT_MS × CLK_HZ/1000 system clocks after reset release.
- R5: The wake write puts WAKE_ADDR on `wr_addr` and a value with only bit WAKE_BIT set on `wr_data`. Request, address and data hold steady until `wr_ack` is seen high at a clock edge.
- R6: `fw_go` rises one clock after `mod_ready` and `mod_irq` are both high. It never rises while only one of them is high.
- R7: A pulse on `fw_done` while `fw_go` is high starts a write of zero to WAKE_ADDR. After that write is acknowledged, `wr_req` and `fw_go` are low and `mod_rst_n` stays high.
- R8: During power-down, `supply_off` rises only after RST_SLOW_CYC+1 synchronised sleep-clock rising edges with reset low. It rises together with `mod_pwr_en` falling.
- R9: If ready and interrupt are not both high within `timeout_ms` milliseconds of the wake acknowledge, `seq_err` goes high with `mod_rst_n` low and `fw_go` low.
- R10: `pwr_dn_req` drives `mod_rst_n` low on the next clock from any active state, including the access wait and the error state. No write request is issued afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low controller reset |
| io_good | input | 1 | IO supply reported good |
| slow_clk | input | 1 | Asynchronous 32.768 kHz sleep clock |
| pwr_up_req | input | 1 | Pulse that starts power-up from idle or off |
| pwr_dn_req | input | 1 | Pulse that starts power-down |
| timeout_ms | input | MS_W | Ready-wait timeout in milliseconds |
| mod_rst_n | output | 1 | Module reset, active low |
| mod_pwr_en | output | 1 | Module power enable, active high |
| supply_off | output | 1 | Supplies may now be removed |
| wr_req | output | 1 | Register write request to serial master |
| wr_addr | output | ADDR_W | Register write address |
| wr_data | output | DATA_W | Register write data |
| wr_ack | input | 1 | Serial master accepted the write |
| mod_ready | input | 1 | Module ready bit as reported |
| mod_irq | input | 1 | Module interrupt line |
| fw_go | output | 1 | Firmware download may proceed |
| fw_done | input | 1 | Firmware loader reports initialisation done |
| seq_err | output | 1 | Ready wait timed out |

## Verification
The bench first withholds the IO supply and then the sleep clock. A sequencer that qualified on only one of them would release reset early. It measures the release-to-write gap in system clocks, which catches a timer that counts from the wrong event or is short by a millisecond. It raises ready and interrupt in both orders and with a long lag between them, so a design that reacted to either one alone would raise the go signal too early. It also forces a timeout and power-down from the access wait and from the error state; there, a missing priority would leave reset high or let a stray write out.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_QUAL,
        S_RSTHOLD,
        S_REL,
        S_ACCWAIT,
        S_WAKE,
        S_WAITRDY,
        S_FW,
        S_CLRWAKE,
        S_RUN,
        S_ERR,
        S_DNHOLD,
        S_OFF
    } seq_state_e;

endpackage

// File: rtl/pwrseq_edge_sync.sv
module pwrseq_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // sh_q[SYNC_STAGES-1] is the synchronised level, sh_q[SYNC_STAGES] its delayed copy
    assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

endmodule

// File: rtl/pwrseq_ms_timer.sv
module pwrseq_ms_timer #(
    parameter int CLK_HZ = 50_000_000,
    parameter int MS_W   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [MS_W-1:0] ms_len,
    output logic            done
);
    localparam int TICKS = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
    localparam int PRE_W = (TICKS > 1) ? $clog2(TICKS) : 1;

    typedef struct packed {
        logic            run;
        logic [MS_W-1:0] left;
        logic [PRE_W-1:0] pre;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.run  = 1'b1;
            tmr_d.left = ms_len;
            tmr_d.pre  = '0;
        end else if (tmr_q.run && tmr_q.left != '0) begin
            if (tmr_q.pre == PRE_W'(TICKS - 1)) begin
                tmr_d.pre  = '0;
                tmr_d.left = tmr_q.left - MS_W'(1);
            end else begin
                tmr_d.pre  = tmr_q.pre + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign done = tmr_q.run && (tmr_q.left == '0);

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int              STABLE_EDGES   = 4,
    parameter int              RST_SLOW_CYC   = 2,
    parameter int              ACCESS_WAIT_MS = 30,
    parameter int              MS_W           = 16,
    parameter int              ADDR_W         = 8,
    parameter int              DATA_W         = 32,
    parameter logic [ADDR_W-1:0] WAKE_ADDR    = 'h1C,
    parameter int              WAKE_BIT       = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_rise,
    input  logic              io_good,
    input  logic              pwr_up_req,
    input  logic              pwr_dn_req,
    input  logic [MS_W-1:0]   timeout_ms,
    input  logic              tmr_done,
    input  logic              wr_ack,
    input  logic              mod_ready,
    input  logic              mod_irq,
    input  logic              fw_done,
    output logic              tmr_start,
    output logic [MS_W-1:0]   tmr_len,
    output logic              mod_rst_n,
    output logic              mod_pwr_en,
    output logic              supply_off,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              fw_go,
    output logic              seq_err
);
    localparam int CNT_MAX = (STABLE_EDGES > RST_SLOW_CYC + 1) ? STABLE_EDGES : RST_SLOW_CYC + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             pwr;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            S_IDLE, S_OFF: begin
                if (pwr_up_req) begin
                    s_d.st  = S_QUAL;
                    s_d.cnt = '0;
                end
            end
            S_QUAL: begin
                if (!io_good) begin
                    s_d.cnt = '0;
                end else if (slow_rise) begin
                    if (s_q.cnt == CNT_W'(STABLE_EDGES - 1)) begin
                        s_d.st  = S_RSTHOLD;
                        s_d.cnt = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + CNT_W'(1);
                    end
                end
            end
            S_RSTHOLD: begin
                if (!io_good) begin
                    s_d.st  = S_QUAL;
                    s_d.cnt = '0;
                end else if (slow_rise) begin
                    if (s_q.cnt == CNT_W'(RST_SLOW_CYC)) s_d.st = S_REL;
                    else                                 s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
            S_REL: begin
                s_d.st  = S_ACCWAIT;
                s_d.pwr = 1'b1;
            end
            S_ACCWAIT: if (tmr_done) s_d.st = S_WAKE;
            S_WAKE:    if (wr_ack)   s_d.st = S_WAITRDY;
            S_WAITRDY: begin
                if (mod_ready && mod_irq) s_d.st = S_FW;
                else if (tmr_done)        s_d.st = S_ERR;
            end
            S_FW:      if (fw_done)  s_d.st = S_CLRWAKE;
            S_CLRWAKE: if (wr_ack)   s_d.st = S_RUN;
            S_RUN, S_ERR: s_d.st = s_q.st;
            S_DNHOLD: begin
                if (slow_rise) begin
                    if (s_q.cnt == CNT_W'(RST_SLOW_CYC)) begin
                        s_d.st  = S_OFF;
                        s_d.pwr = 1'b0;
                    end else begin
                        s_d.cnt = s_q.cnt + CNT_W'(1);
                    end
                end
            end
            default: s_d.st = S_IDLE;
        endcase

        // power-down takes priority over every active state
        if (pwr_dn_req && !(s_q.st inside {S_IDLE, S_OFF, S_DNHOLD})) begin
            s_d.st  = S_DNHOLD;
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: S_IDLE, cnt: '0, pwr: 1'b0};
        else        s_q <= s_d;
    end

    always_comb begin
        mod_rst_n  = s_q.st inside {S_REL, S_ACCWAIT, S_WAKE, S_WAITRDY, S_FW, S_CLRWAKE, S_RUN};
        mod_pwr_en = s_q.pwr;
        supply_off = (s_q.st == S_OFF);
        wr_req     = (s_q.st == S_WAKE) || (s_q.st == S_CLRWAKE);
        wr_addr    = WAKE_ADDR;
        wr_data    = (s_q.st == S_WAKE) ? (DATA_W'(1) << WAKE_BIT) : '0;
        fw_go      = (s_q.st == S_FW);
        seq_err    = (s_q.st == S_ERR);
        tmr_start  = (s_q.st == S_REL) || (s_q.st == S_WAKE && wr_ack);
        tmr_len    = (s_q.st == S_REL) ? MS_W'(ACCESS_WAIT_MS) : timeout_ms;
    end

endmodule

// File: rtl/radio_pwrseq.sv
module radio_pwrseq #(
    parameter int              CLK_HZ         = 50_000_000,
    parameter int              STABLE_EDGES   = 4,
    parameter int              RST_SLOW_CYC   = 2,
    parameter int              ACCESS_WAIT_MS = 30,
    parameter int              MS_W           = 16,
    parameter int              ADDR_W         = 8,
    parameter int              DATA_W         = 32,
    parameter logic [ADDR_W-1:0] WAKE_ADDR    = 'h1C,
    parameter int              WAKE_BIT       = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_good,
    input  logic              slow_clk,
    input  logic              pwr_up_req,
    input  logic              pwr_dn_req,
    input  logic [MS_W-1:0]   timeout_ms,
    output logic              mod_rst_n,
    output logic              mod_pwr_en,
    output logic              supply_off,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ack,
    input  logic              mod_ready,
    input  logic              mod_irq,
    output logic              fw_go,
    input  logic              fw_done,
    output logic              seq_err
);
    logic            slow_rise;
    logic            tmr_start;
    logic            tmr_done;
    logic [MS_W-1:0] tmr_len;

    pwrseq_edge_sync #(.SYNC_STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (slow_clk),
        .rise     (slow_rise)
    );

    pwrseq_ms_timer #(.CLK_HZ(CLK_HZ), .MS_W(MS_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .ms_len (tmr_len),
        .done   (tmr_done)
    );

    pwrseq_fsm #(
        .STABLE_EDGES   (STABLE_EDGES),
        .RST_SLOW_CYC   (RST_SLOW_CYC),
        .ACCESS_WAIT_MS (ACCESS_WAIT_MS),
        .MS_W           (MS_W),
        .ADDR_W         (ADDR_W),
        .DATA_W         (DATA_W),
        .WAKE_ADDR      (WAKE_ADDR),
        .WAKE_BIT       (WAKE_BIT)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_rise  (slow_rise),
        .io_good    (io_good),
        .pwr_up_req (pwr_up_req),
        .pwr_dn_req (pwr_dn_req),
        .timeout_ms (timeout_ms),
        .tmr_done   (tmr_done),
        .wr_ack     (wr_ack),
        .mod_ready  (mod_ready),
        .mod_irq    (mod_irq),
        .fw_done    (fw_done),
        .tmr_start  (tmr_start),
        .tmr_len    (tmr_len),
        .mod_rst_n  (mod_rst_n),
        .mod_pwr_en (mod_pwr_en),
        .supply_off (supply_off),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .fw_go      (fw_go),
        .seq_err    (seq_err)
    );

endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
    parameter int CLK_HZ         = 50_000_000,
    parameter int RST_SLOW_CYC   = 2,
    parameter int ACCESS_WAIT_MS = 30,
    parameter int ADDR_W         = 8,
    parameter int DATA_W         = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slow_rise,
    input logic              pwr_dn_req,
    input logic              mod_rst_n,
    input logic              mod_pwr_en,
    input logic              supply_off,
    input logic              wr_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_ack,
    input logic              mod_ready,
    input logic              mod_irq,
    input logic              fw_go,
    input logic              seq_err
);
    localparam int TICKS    = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
    localparam int WAIT_CYC = ACCESS_WAIT_MS * TICKS;

    logic [7:0]  low_edges;
    logic [31:0] hi_cyc;

    // sleep-clock edges seen while module reset is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               low_edges <= '0;
        else if (mod_rst_n)                       low_edges <= '0;
        else if (slow_rise && low_edges != 8'hFF) low_edges <= low_edges + 8'd1;
    end

    // clocks since module reset release
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          hi_cyc <= '0;
        else if (!mod_rst_n)                 hi_cyc <= '0;
        else if (hi_cyc < 32'(WAIT_CYC))     hi_cyc <= hi_cyc + 32'd1;
    end

    assert_rst_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_rst_n) |-> (32'(low_edges) >= 32'(RST_SLOW_CYC + 1)));

    assert_pwr_after_rst_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_pwr_en) |-> (mod_rst_n && $past(mod_rst_n)));

    assert_no_pwr_at_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_rst_n) |-> !mod_pwr_en);

    assert_access_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (mod_rst_n && hi_cyc >= 32'(WAIT_CYC)));

    assert_wr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack && !pwr_dn_req) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    assert_fw_go_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fw_go) |-> ($past(mod_ready) && $past(mod_irq)));

    assert_supply_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(supply_off) |-> (!mod_rst_n && !mod_pwr_en && 32'(low_edges) >= 32'(RST_SLOW_CYC + 1)));

    assert_err_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> (!mod_rst_n && !fw_go));

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fw_go, seq_err, supply_off, wr_req}));

endmodule

bind radio_pwrseq pwrseq_chk #(
    .CLK_HZ         (CLK_HZ),
    .RST_SLOW_CYC   (RST_SLOW_CYC),
    .ACCESS_WAIT_MS (ACCESS_WAIT_MS),
    .ADDR_W         (ADDR_W),
    .DATA_W         (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slow_rise  (slow_rise),
    .pwr_dn_req (pwr_dn_req),
    .mod_rst_n  (mod_rst_n),
    .mod_pwr_en (mod_pwr_en),
    .supply_off (supply_off),
    .wr_req     (wr_req),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wr_ack     (wr_ack),
    .mod_ready  (mod_ready),
    .mod_irq    (mod_irq),
    .fw_go      (fw_go),
    .seq_err    (seq_err)
);

// File: tb/radio_pwrseq_bench.sv
module radio_pwrseq_bench;
    localparam int CLK_HZ    = 4000;
    localparam int TICKS     = CLK_HZ / 1000;
    localparam int STABLE    = 4;
    localparam int RSTC      = 2;
    localparam int WAIT_MS   = 30;
    localparam int WAKE_BIT  = 3;
    localparam logic [7:0] WADDR = 8'h1C;
    localparam int HALF_SLOW = 7;

    // {timeout_ms, ready lag, irq lag, expect error}
    localparam int VEC [0:3][0:3] = '{
        '{10,   5,   8, 0},
        '{10,  20,   3, 0},
        '{ 3, 200, 250, 1},
        '{ 6,   0,   0, 0}
    };

    logic        clk = 0, rst_n = 0, io_good = 0, slow_clk = 0;
    logic        pwr_up_req = 0, pwr_dn_req = 0, wr_ack = 0;
    logic        mod_ready = 0, mod_irq = 0, fw_done = 0;
    logic [15:0] timeout_ms = 16'd10;
    logic        mod_rst_n, mod_pwr_en, supply_off, wr_req, fw_go, seq_err;
    logic [7:0]  wr_addr;
    logic [31:0] wr_data;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, slow_edges = 0;
    bit slow_run = 1;

    radio_pwrseq #(
        .CLK_HZ(CLK_HZ), .STABLE_EDGES(STABLE), .RST_SLOW_CYC(RSTC),
        .ACCESS_WAIT_MS(WAIT_MS), .MS_W(16), .ADDR_W(8), .DATA_W(32),
        .WAKE_ADDR(WADDR), .WAKE_BIT(WAKE_BIT)
    ) u_radio_pwrseq (
        .clk(clk), .rst_n(rst_n), .io_good(io_good), .slow_clk(slow_clk),
        .pwr_up_req(pwr_up_req), .pwr_dn_req(pwr_dn_req), .timeout_ms(timeout_ms),
        .mod_rst_n(mod_rst_n), .mod_pwr_en(mod_pwr_en), .supply_off(supply_off),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .mod_ready(mod_ready), .mod_irq(mod_irq), .fw_go(fw_go),
        .fw_done(fw_done), .seq_err(seq_err)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always begin
        #(HALF_SLOW * 10 + 3);
        if (slow_run) slow_clk = ~slow_clk;
    end
    always @(posedge slow_clk) slow_edges <= slow_edges + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(150000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual expired expected finish");
        summary();
        $finish;
    end

    task automatic pulse_up();
        pwr_up_req = 1; @(negedge clk); pwr_up_req = 0;
    endtask

    task automatic ack_once();
        wr_ack = 1; @(negedge clk); wr_ack = 0;
    endtask

    task automatic power_down();
        int t0;
        pwr_dn_req = 1; @(negedge clk); pwr_dn_req = 0;
        check(mod_rst_n == 0, "R10", "reset low after down request", mod_rst_n, 0);
        t0 = cyc;
        for (int n = 0; n < 3000 && !supply_off; n++) begin
            @(negedge clk);
            if (wr_req) check(0, "R10", "write after down request", 1, 0);
        end
        check(supply_off == 1, "R8", "supply_off raised", supply_off, 1);
        check(cyc - t0 >= RSTC * 2 * HALF_SLOW, "R8", "clocks before supply off",
              cyc - t0, RSTC * 2 * HALF_SLOW);
        check(mod_pwr_en == 0 && mod_rst_n == 0, "R8", "power and reset low at off",
              {mod_pwr_en, mod_rst_n}, 0);
    endtask

    task automatic run_up(input int tmo, input int rl, input int il, input bit exp_err, input int e0);
        int t_rel, t_wr, k;
        bit both, ok;
        timeout_ms = 16'(tmo);
        for (int n = 0; n < 3000 && !mod_rst_n; n++) @(negedge clk);
        check(mod_rst_n == 1, "R2", "reset released", mod_rst_n, 1);
        check(slow_edges - e0 >= STABLE + RSTC, "R2", "sleep edges before release",
              slow_edges - e0, STABLE + RSTC);
        t_rel = cyc;
        check(mod_pwr_en == 0, "R3", "power enable at release", mod_pwr_en, 0);
        @(negedge clk);
        check(mod_pwr_en == 1, "R3", "power enable one clock later", mod_pwr_en, 1);
        for (int n = 0; n < 1000 && !wr_req; n++) @(negedge clk);
        t_wr = cyc;
        check(t_wr - t_rel >= WAIT_MS * TICKS && t_wr - t_rel <= WAIT_MS * TICKS + 4,
              "R4", "release to wake write clocks", t_wr - t_rel, WAIT_MS * TICKS + 2);
        check(wr_addr == WADDR && wr_data == (32'd1 << WAKE_BIT), "R5", "wake write data",
              wr_data, 32'd1 << WAKE_BIT);
        repeat (2) @(negedge clk);
        check(wr_req && wr_addr == WADDR && wr_data == (32'd1 << WAKE_BIT), "R5",
              "wake write held until ack", wr_data, 32'd1 << WAKE_BIT);
        ack_once();
        ok = 1;
        k = 0;
        for (int i = 0; i < 400; i++) begin
            mod_ready = (i >= rl);
            mod_irq   = (i >= il);
            both = mod_ready && mod_irq;
            @(negedge clk);
            k = i;
            if (exp_err) begin
                if (fw_go) ok = 0;
                if (seq_err) break;
            end else begin
                if (fw_go != both) ok = 0;
                if (both) break;
            end
        end
        if (exp_err) begin
            check(ok, "R9", "no go before timeout", 1, 0);
            check(seq_err == 1 && mod_rst_n == 0 && fw_go == 0, "R9", "error state outputs",
                  {seq_err, mod_rst_n, fw_go}, 3'b100);
            check(k + 1 >= tmo * TICKS, "R9", "clocks until timeout", k + 1, tmo * TICKS);
        end else begin
            check(ok && fw_go == 1, "R6", "go follows ready and irq", fw_go, 1);
            fw_done = 1; @(negedge clk); fw_done = 0;
            check(wr_req == 1 && wr_addr == WADDR && wr_data == 0 && fw_go == 0, "R7",
                  "clear write", wr_data, 0);
            ack_once();
            check(wr_req == 0 && fw_go == 0 && mod_rst_n == 1, "R7", "running after clear",
                  {wr_req, fw_go, mod_rst_n}, 3'b001);
        end
        mod_ready = 0;
        mod_irq   = 0;
    endtask

    initial begin
        int e0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check({mod_rst_n, mod_pwr_en, wr_req, fw_go, supply_off, seq_err} == 0, "R1",
              "reset state", {mod_rst_n, mod_pwr_en, wr_req, fw_go, supply_off, seq_err}, 0);

        // IO supply missing: no release
        pulse_up();
        repeat (300) @(negedge clk);
        check(mod_rst_n == 0, "R1", "held with io_good low", mod_rst_n, 0);
        // sleep clock stopped: no release
        slow_run = 0;
        io_good  = 1;
        repeat (300) @(negedge clk);
        check(mod_rst_n == 0, "R1", "held with sleep clock stopped", mod_rst_n, 0);
        e0 = slow_edges;
        slow_run = 1;

        for (int v = 0; v < 4; v++) begin
            if (v > 0) begin
                e0 = slow_edges;
                pulse_up();
            end
            run_up(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3] != 0, e0);
            power_down();
        end

        // power-down during the access wait
        pulse_up();
        for (int n = 0; n < 3000 && !mod_rst_n; n++) @(negedge clk);
        repeat (20) @(negedge clk);
        check(wr_req == 0, "R4", "no write early in access wait", wr_req, 0);
        power_down();
        repeat (200) @(negedge clk);
        check(wr_req == 0 && supply_off == 1, "R10", "stays off after abort",
              {wr_req, supply_off}, 2'b01);

        summary();
        $finish;
    end

endmodule